// File: doc/BRIEF.md
# Ingress Credit Threshold Bank

This block stores the programmable ingress flow-control thresholds of a four-port switch station. Every port has a set of virtual channels, and each virtual channel has one threshold register for each of the three traffic classes: Posted, Non-Posted and Completion. Each register holds a header credit count (one unit per packet) and a payload credit count (one unit per 16 bytes). The current values of all slots are presented in parallel to the credit-advertisement logic, which lies outside this block.

Software programs the registers over a plain single-cycle write bus and reads them back over a combinational read port. Every write is screened before it commits. The screen checks the header budget of the port the slot belongs to and the payload budget shared by the whole station. When large payloads are in use, it also enforces a floor on the Posted and Completion payload thresholds. A write that fails any rule is dropped, pulses an error output and sets a sticky status bit that software clears by writing a one to it. The block keeps the budget totals as running sums, so each write is judged in the cycle it arrives. There is no streaming data path: all pins are plain control and status signals, with no back-pressure.

Top module: `ict_threshold_bank`

## Requirements
- R1: After reset, the virtual channel 0 slot of every port holds header 12 and payload 144 (Posted), header 7 and payload 7 (Non-Posted), and header 10 and payload 128 (Completion). All other slots hold zero, and the sticky error bit is clear.
- R2: Slot index = (port*NUM_VC + vc)*3 + class, with class 0 Posted, 1 Non-Posted and 2 Completion. Address k < 24 selects slot k. A slot word carries the header threshold in bits [13:9] and the payload threshold in bits [8:0]. A read returns the stored slot word.
- R3: For Posted and Completion slots, payload bits [2:0] are forced to zero on write and read back as zero. For Non-Posted slots, all nine payload bits are stored as written.
- R4: A write is rejected if, after it replaces the old header value of the slot, the sum of header thresholds over all slots of that port would exceed 32. A sum of exactly 32 is accepted.
- R5: A write is rejected if, after it replaces the old payload value of the slot, the sum of payload thresholds over all slots of the station would exceed 1376. A sum of exactly 1376 is accepted.
- R6: While mps256_i is 1, a write to a Posted or Completion slot whose masked payload is below 16 is rejected. While mps256_i is 0, no floor applies, and the floor never applies to Non-Posted slots.
- R7: A rejected write leaves every stored value unchanged. It raises wr_err_o for exactly the cycle after the write and sets the sticky error bit, which reads as bit 0 at address 24.
- R8: A write to address 24 with data bit 0 = 1 clears the sticky error bit. With bit 0 = 0 the bit is left unchanged. A write to address 24 never raises wr_err_o.
- R9: An accepted write appears on hdr_thr_o/pay_thr_o (slot s at bits [s*5 +: 5] and [s*9 +: 9]) and on the read port from the cycle after the write.
- R10: Writes to addresses 25 to 31 change nothing and raise no error. Reads of those addresses return zero.
- R11: The budget checks use the slot's old value being replaced, not added to. A write that lowers a slot is therefore accepted even when the total is at the limit, provided the class floor of R6 is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mps256_i | input | 1 | 1 when the 256-byte maximum payload setting is active (enables the R6 floor) |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 5 | Write address (slot 0..23, status 24) |
| wr_data_i | input | 14 | Write data, header in [13:9], payload in [8:0] |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 14 | Combinational read data |
| wr_err_o | output | 1 | One-cycle pulse after a rejected write |
| hdr_thr_o | output | 120 | Header threshold of every slot, 5 bits each |
| pay_thr_o | output | 216 | Payload threshold of every slot, 9 bits each |

## Verification
A running total that drifts from the stored values shows up at the ports as a wrong accept or reject decision: a write the budget arithmetic should allow gets an error pulse one cycle later, or an overshooting write commits silently. The bench therefore predicts every decision from its own copy of the register contents. It compares wr_err_o, the read port and the parallel outputs right after each write. Because the comparison is made after every write, a corrupted slot or total is exposed within one cycle of the first write whose decision depends on it. Long sweeps that fill, saturate, empty and refill the budgets make that dependency frequent.

// File: rtl/ict_pkg.sv
`timescale 1ns/1ps
package ict_pkg;

  localparam int HDR_W  = 5;
  localparam int PAY_W  = 9;
  localparam int DATA_W = HDR_W + PAY_W;
  localparam int NUM_TC = 3;

  typedef enum logic [1:0] {
    TC_POSTED     = 2'd0,
    TC_NONPOSTED  = 2'd1,
    TC_COMPLETION = 2'd2
  } tclass_e;

  typedef struct packed {
    logic [HDR_W-1:0] hdr;
    logic [PAY_W-1:0] pay;
  } thr_t;

  // Value loaded into a slot at reset.
  function automatic thr_t reset_thr(int vc, tclass_e tc);
    thr_t t;
    t = '0;
    if (vc == 0) begin
      case (tc)
        TC_POSTED:     begin t.hdr = 5'd12; t.pay = 9'd144; end
        TC_NONPOSTED:  begin t.hdr = 5'd7;  t.pay = 9'd7;   end
        TC_COMPLETION: begin t.hdr = 5'd10; t.pay = 9'd128; end
        default:       t = '0;
      endcase
    end
    return t;
  endfunction

  function automatic int reset_port_hdr(int num_vc);
    int s;
    s = 0;
    for (int v = 0; v < num_vc; v++)
      for (int c = 0; c < NUM_TC; c++)
        s += int'(reset_thr(v, tclass_e'(c)).hdr);
    return s;
  endfunction

  function automatic int reset_port_pay(int num_vc);
    int s;
    s = 0;
    for (int v = 0; v < num_vc; v++)
      for (int c = 0; c < NUM_TC; c++)
        s += int'(reset_thr(v, tclass_e'(c)).pay);
    return s;
  endfunction

endpackage

// File: rtl/ict_write_check.sv
`timescale 1ns/1ps
module ict_write_check
  import ict_pkg::*;
#(
  parameter int HDR_BUDGET = 32,
  parameter int PAY_BUDGET = 1376,
  parameter int PAY_MIN    = 16,
  parameter int PSUM_W     = 6,
  parameter int SSUM_W     = 11
) (
  input  tclass_e             tc_i,
  input  logic                mps256_i,
  input  logic [DATA_W-1:0]   raw_i,
  input  thr_t                old_i,
  input  logic [PSUM_W-1:0]   port_sum_i,
  input  logic [SSUM_W-1:0]   stn_sum_i,
  output thr_t                new_o,
  output logic                ok_o
);

  int  hdr_next;
  int  pay_next;
  logic floor_bad;
  thr_t nv;

  always_comb begin
    nv.hdr = raw_i[DATA_W-1:PAY_W];
    nv.pay = raw_i[PAY_W-1:0];
    if (tc_i != TC_NONPOSTED) nv.pay[2:0] = 3'b000;
    hdr_next  = int'(port_sum_i) - int'(old_i.hdr) + int'(nv.hdr);
    pay_next  = int'(stn_sum_i)  - int'(old_i.pay) + int'(nv.pay);
    floor_bad = mps256_i && (tc_i != TC_NONPOSTED) && (int'(nv.pay) < PAY_MIN);
    ok_o      = (hdr_next <= HDR_BUDGET) && (pay_next <= PAY_BUDGET) && !floor_bad;
    new_o     = nv;
  end

endmodule

// File: rtl/ict_slot_store.sv
`timescale 1ns/1ps
module ict_slot_store
  import ict_pkg::*;
#(
  parameter int SLOTS  = 24,
  parameter int NUM_VC = 2,
  parameter int IDX_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        widx_i,
  input  thr_t                    wval_i,
  output thr_t                    wold_o,
  input  logic [IDX_W-1:0]        ridx_i,
  output thr_t                    rval_o,
  output logic [SLOTS*HDR_W-1:0]  hdr_flat_o,
  output logic [SLOTS*PAY_W-1:0]  pay_flat_o
);

  thr_t cur [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int      VC   = (s / NUM_TC) % NUM_VC;
    localparam tclass_e TC   = tclass_e'(s % NUM_TC);
    localparam thr_t    INIT = reset_thr(VC, TC);

    thr_t q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= INIT;
      else if (we_i && widx_i == IDX_W'(s))      q <= wval_i;
    end

    assign cur[s] = q;
    assign hdr_flat_o[s*HDR_W +: HDR_W] = q.hdr;
    assign pay_flat_o[s*PAY_W +: PAY_W] = q.pay;

    if (TC != TC_NONPOSTED) begin : g_align
      // R3
      pay_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pay[2:0] == 3'b000);
    end
  end

  assign wold_o = (int'(widx_i) < SLOTS) ? cur[widx_i] : '0;
  assign rval_o = (int'(ridx_i) < SLOTS) ? cur[ridx_i] : '0;

endmodule

// File: rtl/ict_budget_track.sv
`timescale 1ns/1ps
module ict_budget_track
  import ict_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_VC     = 2,
  parameter int HDR_BUDGET = 32,
  parameter int PAY_BUDGET = 1376,
  parameter int PORT_W     = 2,
  parameter int PSUM_W     = 6,
  parameter int SSUM_W     = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit_i,
  input  logic [PORT_W-1:0]           port_i,
  input  thr_t                        old_i,
  input  thr_t                        new_i,
  output logic [NUM_PORTS*PSUM_W-1:0] port_sums_o,
  output logic [SSUM_W-1:0]           stn_sum_o
);

  localparam int RST_HDR = reset_port_hdr(NUM_VC);
  localparam int RST_PAY = NUM_PORTS * reset_port_pay(NUM_VC);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PSUM_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= PSUM_W'(RST_HDR);
      else if (commit_i && port_i == PORT_W'(p))
        q <= q - PSUM_W'(old_i.hdr) + PSUM_W'(new_i.hdr);
    end

    assign port_sums_o[p*PSUM_W +: PSUM_W] = q;

    // R4
    hdr_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q) <= HDR_BUDGET);
  end

  logic [SSUM_W-1:0] stn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stn_q <= SSUM_W'(RST_PAY);
    else if (commit_i) stn_q <= stn_q - SSUM_W'(old_i.pay) + SSUM_W'(new_i.pay);
  end

  assign stn_sum_o = stn_q;

  // R5
  pay_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stn_q) <= PAY_BUDGET);

endmodule

// File: rtl/ict_threshold_bank.sv
`timescale 1ns/1ps
module ict_threshold_bank
  import ict_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_VC     = 2,
  parameter int HDR_BUDGET = 32,
  parameter int PAY_BUDGET = 1376,
  parameter int PAY_MIN    = 16,
  localparam int SLOTS     = NUM_PORTS * NUM_VC * NUM_TC,
  localparam int ADDR_W    = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mps256_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    wr_err_o,
  output logic [SLOTS*HDR_W-1:0]  hdr_thr_o,
  output logic [SLOTS*PAY_W-1:0]  pay_thr_o
);

  localparam int STATUS_ADDR    = SLOTS;
  localparam int SLOTS_PER_PORT = NUM_VC * NUM_TC;
  localparam int PORT_W         = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int PSUM_W         = $clog2(HDR_BUDGET + 1);
  localparam int SSUM_W         = $clog2(PAY_BUDGET + 1);

  // write decode
  logic              wr_is_slot, wr_is_stat, wr_ok, commit;
  logic [PORT_W-1:0] wr_port;
  tclass_e           wr_tc;

  assign wr_is_slot = int'(wr_addr_i) < SLOTS;
  assign wr_is_stat = int'(wr_addr_i) == STATUS_ADDR;
  assign wr_port    = PORT_W'(int'(wr_addr_i) / SLOTS_PER_PORT);
  assign wr_tc      = tclass_e'(2'(int'(wr_addr_i) % NUM_TC));
  assign commit     = wr_en_i && wr_is_slot && wr_ok;

  thr_t old_thr, new_thr, rd_thr;
  logic [NUM_PORTS*PSUM_W-1:0] port_sums;
  logic [SSUM_W-1:0]           stn_sum;
  logic [PSUM_W-1:0]           sel_port_sum;

  assign sel_port_sum = port_sums[wr_port*PSUM_W +: PSUM_W];

  ict_write_check #(
    .HDR_BUDGET(HDR_BUDGET), .PAY_BUDGET(PAY_BUDGET), .PAY_MIN(PAY_MIN),
    .PSUM_W(PSUM_W), .SSUM_W(SSUM_W)
  ) u_check (
    .tc_i(wr_tc), .mps256_i(mps256_i), .raw_i(wr_data_i), .old_i(old_thr),
    .port_sum_i(sel_port_sum), .stn_sum_i(stn_sum), .new_o(new_thr), .ok_o(wr_ok)
  );

  ict_slot_store #(.SLOTS(SLOTS), .NUM_VC(NUM_VC), .IDX_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(commit), .widx_i(wr_addr_i), .wval_i(new_thr),
    .wold_o(old_thr), .ridx_i(rd_addr_i), .rval_o(rd_thr),
    .hdr_flat_o(hdr_thr_o), .pay_flat_o(pay_thr_o)
  );

  ict_budget_track #(
    .NUM_PORTS(NUM_PORTS), .NUM_VC(NUM_VC), .HDR_BUDGET(HDR_BUDGET),
    .PAY_BUDGET(PAY_BUDGET), .PORT_W(PORT_W), .PSUM_W(PSUM_W), .SSUM_W(SSUM_W)
  ) u_budget (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .port_i(wr_port),
    .old_i(old_thr), .new_i(new_thr), .port_sums_o(port_sums), .stn_sum_o(stn_sum)
  );

  // error pulse and sticky status
  logic err_q, sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      err_q <= wr_en_i && wr_is_slot && !wr_ok;
      if (wr_en_i && wr_is_slot && !wr_ok)             sticky_q <= 1'b1;
      else if (wr_en_i && wr_is_stat && wr_data_i[0])  sticky_q <= 1'b0;
    end
  end

  assign wr_err_o = err_q;

  always_comb begin
    if (int'(rd_addr_i) < SLOTS)            rd_data_o = {rd_thr.hdr, rd_thr.pay};
    else if (int'(rd_addr_i) == STATUS_ADDR) rd_data_o = DATA_W'(sticky_q);
    else                                     rd_data_o = '0;
  end

  // station payload recomputed from stored values for cross-checking
  int pay_total;
  always_comb begin
    pay_total = 0;
    for (int i = 0; i < SLOTS; i++) pay_total += int'(pay_thr_o[i*PAY_W +: PAY_W]);
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |-> sticky_q);

  // R7
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_is_slot && !wr_ok) |=> ($stable(hdr_thr_o) && $stable(pay_thr_o)));

  // R8
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_is_stat && wr_data_i[0]) |=> (!sticky_q && !wr_err_o));

  // R10
  unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_is_slot) |=> ($stable(hdr_thr_o) && $stable(pay_thr_o) && !wr_err_o));

  // R11
  total_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stn_sum) == pay_total);

endmodule

// File: tb/sim_ict_threshold_bank.sv
`timescale 1ns/1ps
module sim_ict_threshold_bank;

  localparam int SLOTS = 24;
  localparam int STAT  = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mps256 = 1'b0;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_addr = '0;
  logic [13:0]  wr_data = '0;
  logic [4:0]   rd_addr = '0;
  logic [13:0]  rd_data;
  logic         wr_err;
  logic [119:0] hdr_thr;
  logic [215:0] pay_thr;

  always #5 clk = ~clk;

  ict_threshold_bank u0 (
    .clk(clk), .rst_n(rst_n), .mps256_i(mps256), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .wr_err_o(wr_err), .hdr_thr_o(hdr_thr), .pay_thr_o(pay_thr)
  );

  int checks = 0;
  int errors = 0;
  int mh [SLOTS];
  int mp [SLOTS];
  bit msticky;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int def_h(int s);
    if ((s / 3) % 2 != 0) return 0;
    case (s % 3) 0: return 12; 1: return 7; default: return 10; endcase
  endfunction

  function automatic int def_p(int s);
    if ((s / 3) % 2 != 0) return 0;
    case (s % 3) 0: return 144; 1: return 7; default: return 128; endcase
  endfunction

  task automatic rd_chk(input int a, input int exp, input string req);
    @(negedge clk);
    rd_addr = a[4:0];
    #1;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic slot_chk(input int s, input string req);
    chk(req, int'(hdr_thr[s*5 +: 5]), mh[s]);
    chk(req, int'(pay_thr[s*9 +: 9]), mp[s]);
    rd_addr = s[4:0];
    #1;
    chk(req, int'(rd_data), mh[s] * 512 + mp[s]);
  endtask

  task automatic full_chk(input string req);
    @(negedge clk);
    for (int s = 0; s < SLOTS; s++) slot_chk(s, req);
  endtask

  // One write with the decision predicted from the model.
  task automatic wr(input int a, input int d, input bit mps, input string req);
    bit slot, ok;
    int nh, np, hs, ps, port, tc;
    slot = (a < SLOTS);
    ok   = 1;
    if (slot) begin
      tc = a % 3;
      port = a / 6;
      nh = (d >> 9) & 31;
      np = d & 511;
      if (tc != 1) np = np & ~7;
      hs = 0;
      ps = 0;
      for (int s = port * 6; s < port * 6 + 6; s++) hs += (s == a) ? nh : mh[s];
      for (int s = 0; s < SLOTS; s++) ps += (s == a) ? np : mp[s];
      ok = (hs <= 32) && (ps <= 1376) && !(mps && tc != 1 && np < 16);
    end
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = a[4:0];
    wr_data = d[13:0];
    mps256 = mps;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    chk({req, " err"}, int'(wr_err), (slot && !ok) ? 1 : 0);
    if (slot && ok) begin mh[a] = nh; mp[a] = np; end
    if (slot && !ok) msticky = 1;
    if (a == STAT && d[0]) msticky = 0;
    if (slot) slot_chk(a, req);
    rd_addr = 5'(STAT);
    #1;
    chk({req, " sticky"}, int'(rd_data), int'(msticky));
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int s = 0; s < SLOTS; s++) begin mh[s] = def_h(s); mp[s] = def_p(s); end
    msticky = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 unmapped reads
    full_chk("R1");
    rd_chk(STAT, 0, "R1");
    chk("R1 err", int'(wr_err), 0);
    for (int a = 25; a < 32; a++) rd_chk(a, 0, "R10");

    // R2/R3: Non-Posted slot keeps all payload bits; port 0 header reaches 32 exactly (R4 boundary)
    wr(4, (3 << 9) | 245, 0, "R2");
    chk("R4 boundary accept", mh[4], 3);
    chk("R3 np bits", mp[4], 245);
    // R4: one header over budget
    wr(5, (1 << 9), 0, "R4");
    // R7: error pulse lasts one cycle
    @(posedge clk);
    #1;
    chk("R7 pulse end", int'(wr_err), 0);
    chk("R7 sticky", msticky, 1);
    // R8
    wr(STAT, 0, 0, "R8 keep");
    chk("R8 keep", msticky, 1);
    wr(STAT, 1, 0, "R8 clear");
    // R5: station 1361 + 16 = 1377 rejected; masked low bits (R3)
    wr(3, 23, 0, "R5");
    // R11: replace 245 by 260 -> exactly 1376 accepted
    wr(4, (3 << 9) | 260, 0, "R11");
    chk("R5 boundary", mp[4], 260);
    wr(3, 8, 0, "R5 over");
    // R11: lowering a slot at the limit is accepted
    wr(0, (12 << 9) | 136, 0, "R11 lower");
    chk("R11 lower", mp[0], 136);
    // R6 floor
    wr(0, (12 << 9) | 15, 1, "R6 floor P");
    wr(2, (10 << 9) | 8, 1, "R6 floor C");
    wr(0, (12 << 9) | 16, 1, "R6 min ok");
    wr(0, (12 << 9) | 8, 0, "R6 off");
    wr(1, (7 << 9) | 3, 1, "R6 np");
    wr(STAT, 1, 0, "R8");
    // R10 unmapped writes
    for (int a = 25; a < 32; a++) wr(a, 14'h3fff, a[0], "R10");
    full_chk("R10");
    // R3 mask on Completion with all bits
    wr(8, 14'h01ff, 0, "R3");

    // sweep 1
    for (int s = 0; s < SLOTS; s++)
      for (int h = 0; h < 32; h++)
        wr(s, (h << 9) | ((h * 37 + s * 53) % 512), (h % 4) == 0, "R9 sweep");
    full_chk("R9");
    // empty every slot
    for (int s = 0; s < SLOTS; s++) wr(s, 0, 0, "R11 drain");
    // sweep 2, small values mostly accepted
    for (int s = 0; s < SLOTS; s++)
      for (int h = 0; h < 8; h++)
        wr(s, (h << 9) | ((h * 29 + s * 17) % 96), (h % 2) == 1, "R4 R5 R6 sweep");
    full_chk("R9");
    wr(STAT, 1, 0, "R8 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end

endmodule